// File: doc/BRIEF.md
# Half-Bridge Command Interlock with Glitch Filtering

This block sits between a controller and the gate drivers of one half-bridge leg. It takes two logic commands, one for the upper switch and one for the lower switch, plus a fault-clear command. Each input is synchronised to the system clock and then debounced. A debounced level changes only after the raw input has held its new value for a programmable number of clock cycles, so short noise pulses never reach the switches.

The two debounced switch commands feed an interlock. The interlock never lets both gate outputs be on together. If both commands are high, the gate state the block already had is kept. If both commands rise in the same cycle, the upper switch wins. When an overlap ends with one command still high, the pattern of that command is applied only after a programmable delay-matching interval. The upper gate is set by rising edges of its command, while the lower gate follows the level of its command. A force-off input from the protection logic blanks both gates in the same cycle and clears the held state. The debounced fault-clear level is passed out for the protection logic.

Top module: `halfBridgeInterlock`

## Requirements
- R1: While reset is asserted, and on leaving reset, both gate outputs and the debounced fault-clear output are 0.
- R2: Each of the three command inputs is debounced. A change that lasts fewer than FILT_LEN clock cycles never reaches the debounced level. A change that lasts FILT_LEN cycles or more is taken up.
- R3: If only the upper command is high, the upper gate turns on and the lower gate is off. If only the lower command is high, the lower gate is on and the upper gate is off. If both commands are low, both gates are off.
- R4: While both debounced commands stay high, both gate outputs keep the values they had when the overlap began.
- R5: If both debounced commands rise in the same cycle, the upper gate turns on and the lower gate stays off.
- R6: When an overlap ends with exactly one command still high, the gates keep their previous values for DLY_LEN extra cycles. After that they take the pattern of the remaining command, which is DLY_LEN cycles later than the same command change outside an overlap.
- R7: The upper gate turns on only on a rising edge of its debounced command. After a force-off has been released, an upper command that is still high keeps the gate off until the command makes a new rising edge. The lower gate follows its command level and resumes at once.
- R8: While forceOff is 1, both gate outputs are 0 in the same cycle, with no clock edge needed, and the held gate state is cleared to both-off.
- R9: hiGate and loGate are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiCmd | input | 1 | Raw upper-switch command |
| loCmd | input | 1 | Raw lower-switch command |
| clrCmd | input | 1 | Raw fault-clear command |
| forceOff | input | 1 | Shutdown request from protection logic, active high |
| hiGate | output | 1 | Upper gate command |
| loGate | output | 1 | Lower gate command |
| clrFilt | output | 1 | Debounced fault-clear level |

## Verification
The interlock is driven through a sequence of command patterns. Single commands, both low, an overlap entered from either side, a simultaneous rise, and overlap exits towards each side tell hold behaviour apart from plain level following. Force-off is applied with each gate on, and then released with the command still high. This separates the edge-set upper gate from the level-following lower gate. For the debounce, pulses one cycle shorter than the limit are compared with pulses exactly at the limit. For the delay-matching interval, an overlap-exit latency is measured against a plain-edge latency, and the difference must be exactly DLY_LEN cycles.

// File: rtl/ilkPkg.sv
package ilkPkg;

  // Strobes issued by the control to the datapath state register and delay timer
  typedef struct packed {
    logic setHi;
    logic setLo;
    logic setOff;
    logic armDly;
    logic dropDly;
  } ilkStrobe_t;

  // Observations the datapath hands back to the control
  typedef struct packed {
    logic hiFilt;
    logic loFilt;
    logic hiPrev;
    logic loPrev;
    logic dlyBusy;
    logic dlyDone;
    logic hiState;
    logic loState;
  } ilkStatus_t;

  // Debounced command pattern, bit 1 = upper, bit 0 = lower
  typedef enum logic [1:0] {
    PAT_NONE = 2'b00,
    PAT_LO   = 2'b01,
    PAT_HI   = 2'b10,
    PAT_BOTH = 2'b11
  } ilkPat_e;

endpackage

// File: rtl/ilkGlitchFilter.sv
module ilkGlitchFilter #(
  parameter int FILT_LEN    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          runCnt;
  logic                   filtQ;
  logic                   syncLvl;

  assign syncLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  // Count consecutive cycles that differ from the accepted level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      filtQ  <= 1'b0;
    end else if (syncLvl == filtQ) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_LEN - 1)) begin
      runCnt <= '0;
      filtQ  <= syncLvl;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign filtOut = filtQ;
endmodule

// File: rtl/ilkDatapath.sv
module ilkDatapath
  import ilkPkg::*;
#(
  parameter int FILT_LEN    = 50,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_LEN     = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hiCmd,
  input  logic       loCmd,
  input  logic       clrCmd,
  input  ilkStrobe_t strobe,
  output ilkStatus_t status,
  output logic       clrFilt
);
  localparam int NCH = 3;
  localparam int DW  = $clog2(DLY_LEN + 1);

  logic [NCH-1:0] rawVec;
  logic [NCH-1:0] filtVec;
  logic           hiPrevQ, loPrevQ;
  logic           hiQ, loQ;
  logic [DW-1:0]  dlyCnt;

  assign rawVec = {clrCmd, loCmd, hiCmd};

  for (genvar ch = 0; ch < NCH; ch++) begin : gFilt
    ilkGlitchFilter #(
      .FILT_LEN   (FILT_LEN),
      .SYNC_STAGES(SYNC_STAGES)
    ) uFilt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawVec[ch]),
      .filtOut(filtVec[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiPrevQ <= 1'b0;
      loPrevQ <= 1'b0;
    end else begin
      hiPrevQ <= filtVec[0];
      loPrevQ <= filtVec[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dlyCnt <= '0;
    else if (strobe.dropDly)  dlyCnt <= '0;
    else if (strobe.armDly)   dlyCnt <= DW'(DLY_LEN);
    else if (dlyCnt != '0)    dlyCnt <= dlyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= 1'b0;
      loQ <= 1'b0;
    end else if (strobe.setOff) begin
      hiQ <= 1'b0;
      loQ <= 1'b0;
    end else if (strobe.setHi) begin
      hiQ <= 1'b1;
      loQ <= 1'b0;
    end else if (strobe.setLo) begin
      hiQ <= 1'b0;
      loQ <= 1'b1;
    end
  end

  assign status.hiFilt  = filtVec[0];
  assign status.loFilt  = filtVec[1];
  assign status.hiPrev  = hiPrevQ;
  assign status.loPrev  = loPrevQ;
  assign status.dlyBusy = (dlyCnt != '0);
  assign status.dlyDone = (dlyCnt == DW'(1));
  assign status.hiState = hiQ;
  assign status.loState = loQ;
  assign clrFilt        = filtVec[2];
endmodule

// File: rtl/ilkControl.sv
module ilkControl
  import ilkPkg::*;
(
  input  logic       forceOff,
  input  ilkStatus_t status,
  output ilkStrobe_t strobe
);
  ilkPat_e pat;
  logic    hiRise, loRise, leavingBoth;

  assign pat         = ilkPat_e'({status.hiFilt, status.loFilt});
  assign hiRise      = status.hiFilt & ~status.hiPrev;
  assign loRise      = status.loFilt & ~status.loPrev;
  assign leavingBoth = status.hiPrev & status.loPrev;

  always_comb begin
    strobe = '0;
    if (forceOff) begin
      strobe.setOff  = 1'b1;
      strobe.dropDly = 1'b1;
    end else if (status.dlyBusy) begin
      unique case (pat)
        PAT_BOTH: strobe.dropDly = 1'b1;
        PAT_NONE: begin
          strobe.dropDly = 1'b1;
          strobe.setOff  = 1'b1;
        end
        default: begin
          if (status.dlyDone) begin
            strobe.dropDly = 1'b1;
            strobe.setHi   = (pat == PAT_HI);
            strobe.setLo   = (pat == PAT_LO);
          end
        end
      endcase
    end else begin
      unique case (pat)
        PAT_NONE: strobe.setOff = 1'b1;
        PAT_HI: begin
          if (leavingBoth)          strobe.armDly = 1'b1;
          else if (hiRise)          strobe.setHi  = 1'b1;
          else if (status.loState)  strobe.setOff = 1'b1;
        end
        PAT_LO: begin
          if (leavingBoth) strobe.armDly = 1'b1;
          else             strobe.setLo  = 1'b1;
        end
        PAT_BOTH: begin
          if (hiRise && loRise) strobe.setHi = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/halfBridgeInterlock.sv
module halfBridgeInterlock
  import ilkPkg::*;
#(
  parameter int FILT_LEN    = 50,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_LEN     = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiCmd,
  input  logic loCmd,
  input  logic clrCmd,
  input  logic forceOff,
  output logic hiGate,
  output logic loGate,
  output logic clrFilt
);
  ilkStrobe_t strobe;
  ilkStatus_t status;

  logic hiFilt, loFilt, hiPrev, loPrev, hiState, loState;

  ilkDatapath #(
    .FILT_LEN   (FILT_LEN),
    .SYNC_STAGES(SYNC_STAGES),
    .DLY_LEN    (DLY_LEN)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .hiCmd  (hiCmd),
    .loCmd  (loCmd),
    .clrCmd (clrCmd),
    .strobe (strobe),
    .status (status),
    .clrFilt(clrFilt)
  );

  ilkControl uCtl (
    .forceOff(forceOff),
    .status  (status),
    .strobe  (strobe)
  );

  assign hiFilt  = status.hiFilt;
  assign loFilt  = status.loFilt;
  assign hiPrev  = status.hiPrev;
  assign loPrev  = status.loPrev;
  assign hiState = status.hiState;
  assign loState = status.loState;

  // Shutdown blanks the gates without waiting for a clock edge
  assign hiGate = hiState & ~forceOff;
  assign loGate = loState & ~forceOff;
endmodule

// File: rtl/ilkChecker.sv
module ilkChecker (
  input logic clk,
  input logic rstN,
  input logic forceOff,
  input logic hiGate,
  input logic loGate,
  input logic hiFilt,
  input logic loFilt,
  input logic hiPrev,
  input logic loPrev,
  input logic hiState,
  input logic loState
);
  assert_gates_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(hiGate && loGate));

  assert_force_blanks_R8: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |-> (!hiGate && !loGate));

  assert_force_clears_state_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(forceOff) |-> (!hiState && !loState));

  assert_both_low_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!hiFilt && !loFilt) |-> (!hiState && !loState));

  assert_overlap_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(hiFilt && loFilt && hiPrev && loPrev && !forceOff)
      |-> (hiState == $past(hiState) && loState == $past(loState)));

  assert_joint_rise_hi_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(hiFilt && loFilt && !hiPrev && !loPrev && !forceOff)
      |-> (hiState && !loState));
endmodule

bind halfBridgeInterlock ilkChecker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .forceOff(forceOff),
  .hiGate  (hiGate),
  .loGate  (loGate),
  .hiFilt  (hiFilt),
  .loFilt  (loFilt),
  .hiPrev  (hiPrev),
  .loPrev  (loPrev),
  .hiState (hiState),
  .loState (loState)
);

// File: tb/tb_halfBridgeInterlock.sv
module tb_halfBridgeInterlock;
  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 8;
  localparam int SYNC       = 2;
  localparam int DLY        = 6;
  localparam int SETTLE     = 30;
  localparam int NVEC       = 17;

  // {hiCmd, loCmd, forceOff, expHi, expLo}
  localparam logic [4:0] VECS [NVEC] = '{
    5'b000_00, 5'b100_10, 5'b000_00, 5'b010_01, 5'b110_01,
    5'b010_01, 5'b000_00, 5'b110_10, 5'b100_10, 5'b101_00,
    5'b100_00, 5'b000_00, 5'b100_10, 5'b110_10, 5'b010_01,
    5'b011_00, 5'b010_01
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hiCmd = 1'b0, loCmd = 1'b0, clrCmd = 1'b0, forceOff = 1'b0;
  logic hiGate, loGate, clrFilt;
  int   nChecks = 0, nFails = 0;
  bit   finished = 1'b0;
  bit   overlapSeen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfBridgeInterlock #(.FILT_LEN(FILT), .SYNC_STAGES(SYNC), .DLY_LEN(DLY)) dut (
    .clk(clk), .rstN(rstN), .hiCmd(hiCmd), .loCmd(loCmd), .clrCmd(clrCmd),
    .forceOff(forceOff), .hiGate(hiGate), .loGate(loGate), .clrFilt(clrFilt)
  );

  // R9: watch every cycle
  always @(negedge clk) if (rstN && hiGate && loGate) overlapSeen = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string rowTag(input int r);
    case (r)
      4, 13:        return "R4";
      7:            return "R5";
      5, 8, 14:     return "R6";
      10, 12, 16:   return "R7";
      9, 15:        return "R8";
      default:      return "R3";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int base, n;
    bit seen;

    // R1: reset state
    hiCmd = 1'b1; clrCmd = 1'b1;
    waitCyc(SETTLE);
    check(!hiGate && !loGate && !clrFilt, "R1 in reset", {hiGate, loGate, clrFilt}, 0);
    hiCmd = 1'b0; clrCmd = 1'b0;
    waitCyc(SETTLE);
    rstN = 1'b1;
    waitCyc(2);
    check(!hiGate && !loGate && !clrFilt, "R1 after reset", {hiGate, loGate, clrFilt}, 0);

    // Vector table
    for (int r = 0; r < NVEC; r++) begin
      {hiCmd, loCmd, forceOff} = VECS[r][4:2];
      waitCyc(SETTLE);
      check({hiGate, loGate} == VECS[r][1:0], rowTag(r), {hiGate, loGate}, VECS[r][1:0]);
    end
    {hiCmd, loCmd, forceOff} = 3'b000;
    waitCyc(SETTLE);

    // R2: debounce on upper command
    seen = 1'b0;
    hiCmd = 1'b1; waitCyc(FILT - 1); hiCmd = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (hiGate) seen = 1'b1; end
    check(!seen, "R2 short hi pulse", seen, 0);
    seen = 1'b0;
    hiCmd = 1'b1; waitCyc(FILT); hiCmd = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (hiGate) seen = 1'b1; end
    check(seen, "R2 full hi pulse", seen, 1);

    // R2: debounce on fault clear
    seen = 1'b0;
    clrCmd = 1'b1; waitCyc(FILT - 1); clrCmd = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (clrFilt) seen = 1'b1; end
    check(!seen, "R2 short clr pulse", seen, 0);
    seen = 1'b0;
    clrCmd = 1'b1; waitCyc(FILT); clrCmd = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (clrFilt) seen = 1'b1; end
    check(seen, "R2 full clr pulse", seen, 1);

    // R6: overlap exit latency exceeds plain latency by DLY
    hiCmd = 1'b1; base = 0;
    do begin @(negedge clk); base++; end while (!hiGate && base < 100);
    hiCmd = 1'b0; waitCyc(SETTLE);
    loCmd = 1'b1; waitCyc(SETTLE);
    hiCmd = 1'b1; waitCyc(SETTLE);
    check(loGate && !hiGate, "R4 overlap from lo", {hiGate, loGate}, 1);
    loCmd = 1'b0; n = 0;
    do begin @(negedge clk); n++; end while (!hiGate && n < 100);
    check(n == base + DLY, "R6 exit delay", n, base + DLY);
    check(!loGate, "R6 lo released", loGate, 0);

    // R8: force-off acts without a clock edge
    hiCmd = 1'b0; loCmd = 1'b1; waitCyc(SETTLE);
    forceOff = 1'b1; #1;
    check(!loGate && !hiGate, "R8 immediate blank", {hiGate, loGate}, 0);
    waitCyc(2);
    forceOff = 1'b0; #1;
    check(!loGate, "R8 state cleared", loGate, 0);
    waitCyc(3);
    check(loGate, "R7 lo resumes by level", loGate, 1);

    check(!overlapSeen, "R9 gates exclusive", overlapSeen, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule